// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block runs the read cycles of an asynchronous external static memory. A read request names one of several chip selects and an address. The block registers the address and starts a cycle counter. From that counter it forms two active-low waveforms: a read strobe shared by all memories, and the chip-select line of the addressed memory. Each chip select has its own timing set. That set gives a setup and a pulse length for the read strobe, a setup and a pulse length for the chip select, and one total cycle length. Neither hold time is stored. Each hold is whatever is left of the total cycle after that strobe's setup and pulse.

Read data is sampled on the clock edge that ends the read-strobe pulse. A one-cycle done flag marks the last count of the cycle. A request that is already waiting when done is high may start on that same edge, but only if it targets the chip select that is in use. A request for a different chip select waits one idle clock, so the old chip select is high before the new one falls. With zero setup and zero hold, consecutive reads to one memory keep the strobes low across the boundary between cycles.

The timing configuration for a chip select must not change while a read to it is in progress.

Top module: `smc_read_timer`

## Requirements
- R1: `mem_addr` takes `req_addr` on the edge where `req_take` is high. It then stays unchanged until the next accepted request. After reset it is zero.
- R2: Count k=0 is the first clock after acceptance. With an effective cycle length C, a read setup S and an effective pulse P, `mem_rd_n` is low exactly for the counts S <= k < min(S+P, C). Field i of each configuration vector occupies bits [i*W +: W], where W is the width of that field.
- R3: During a read, only the bit `mem_cs_n[cs]` of the addressed chip select can be low. It follows the same window rule as R2, using the chip-select setup and pulse. All other chip-select bits stay high.
- R4: A cycle length of 0 behaves as 1. A setup of C or more behaves as C-1. A pulse of 0 behaves as 1. As a result, every read drives both strobes low at least once.
- R5: `done` is high for exactly the last count, k = C-1, of each read and is low otherwise.
- R6: `cap_strobe` is high in the last low count of the read-strobe window. On the edge that ends that count, `rd_data` loads `mem_dq`. At all other times `rd_data` holds its value.
- R7: `req_take` is high when `req_valid` is high and either no read is active, or `done` is high and `req_cs` equals the active chip select. Otherwise it is low.
- R8: When the next read targets a different chip select, there is at least one clock with every chip-select bit and `mem_rd_n` high before the new chip select falls.
- R9: Consider back-to-back reads to the same chip select, where a strobe has zero setup and its setup plus pulse equals the cycle length. That strobe stays low continuously across all the reads.
- R10: During and right after reset, all strobes are high, `done`, `cap_strobe` and `req_take` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request pending, held until taken |
| req_cs | input | CSW | Chip select index of the request |
| req_addr | input | AW | Address of the request |
| cfg_rd_setup | input | NCS*SETW | Per-select read-strobe setup, in clocks |
| cfg_rd_pulse | input | NCS*PULW | Per-select read-strobe pulse, in clocks |
| cfg_cs_setup | input | NCS*SETW | Per-select chip-select setup, in clocks |
| cfg_cs_pulse | input | NCS*PULW | Per-select chip-select pulse, in clocks |
| cfg_cycle | input | NCS*CYCW | Per-select total read cycle, in clocks |
| mem_dq | input | DW | Data returned by the memory |
| req_take | output | 1 | Request accepted on the coming edge |
| mem_addr | output | AW | Address bus to the memory |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NCS | Active-low chip selects |
| cap_strobe | output | 1 | Read data is sampled at the end of this clock |
| rd_data | output | DW | Last captured read data |
| done | output | 1 | Last clock of the current read |

## Verification
Three events can land in the same clock. The first is the data capture, which shares the last count with `done` whenever the read-strobe hold is zero or the pulse is clamped to the end of the cycle. The second is the acceptance of the next request, which takes place on the `done` edge when the next read goes to the same chip select. The bench provokes all three together: it sets up timings with zero hold and clamped pulses and keeps requests waiting back to back. Its behavioural model then judges every clock. It checks that the captured word belongs to the finishing read, that the new address appears only after that edge, and that a change of chip select costs exactly one idle clock.

// File: rtl/smc_read_timer.sv
module smc_read_timer #(
  parameter int NCS  = 4,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int SETW = 6,
  parameter int PULW = 7,
  parameter int CYCW = 9,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int EW  = CYCW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CSW-1:0]       req_cs,
  input  logic [AW-1:0]        req_addr,
  input  logic [NCS*SETW-1:0]  cfg_rd_setup,
  input  logic [NCS*PULW-1:0]  cfg_rd_pulse,
  input  logic [NCS*SETW-1:0]  cfg_cs_setup,
  input  logic [NCS*PULW-1:0]  cfg_cs_pulse,
  input  logic [NCS*CYCW-1:0]  cfg_cycle,
  input  logic [DW-1:0]        mem_dq,
  output logic                 req_take,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_rd_n,
  output logic [NCS-1:0]       mem_cs_n,
  output logic                 cap_strobe,
  output logic [DW-1:0]        rd_data,
  output logic                 done
);

  logic            busy;
  logic [CYCW-1:0] cnt;
  logic [CSW-1:0]  cur;

  function automatic logic [EW-1:0] first_cnt(input logic [EW-1:0] s, input logic [EW-1:0] c);
    return (s >= c) ? c - 1'b1 : s;
  endfunction

  function automatic logic [EW-1:0] end_cnt(input logic [EW-1:0] s, input logic [EW-1:0] p,
                                            input logic [EW-1:0] c);
    logic [EW-1:0] e;
    e = s + ((p == '0) ? EW'(1) : p);
    return (e > c) ? c : e;
  endfunction

  logic [EW-1:0] cyc, k, rd_beg, rd_end, cs_beg, cs_end;
  logic          rd_on, cs_on;

  assign cyc    = (cfg_cycle[cur*CYCW +: CYCW] == '0) ? EW'(1) : EW'(cfg_cycle[cur*CYCW +: CYCW]);
  assign k      = EW'(cnt);
  assign rd_beg = first_cnt(EW'(cfg_rd_setup[cur*SETW +: SETW]), cyc);
  assign rd_end = end_cnt(rd_beg, EW'(cfg_rd_pulse[cur*PULW +: PULW]), cyc);
  assign cs_beg = first_cnt(EW'(cfg_cs_setup[cur*SETW +: SETW]), cyc);
  assign cs_end = end_cnt(cs_beg, EW'(cfg_cs_pulse[cur*PULW +: PULW]), cyc);

  assign rd_on      = busy && (k >= rd_beg) && (k < rd_end);
  assign cs_on      = busy && (k >= cs_beg) && (k < cs_end);
  assign done       = busy && (k == cyc - 1'b1);
  assign cap_strobe = busy && (k == rd_end - 1'b1);
  assign req_take   = req_valid && (!busy || (done && req_cs == cur));
  assign mem_rd_n   = !rd_on;

  always_comb begin
    mem_cs_n = '1;
    for (int i = 0; i < NCS; i++)
      if (cs_on && cur == CSW'(i)) mem_cs_n[i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      mem_addr <= '0;
      rd_data  <= '0;
    end else begin
      if (cap_strobe) rd_data <= mem_dq;
      if (req_take) begin
        busy     <= 1'b1;
        cnt      <= '0;
        cur      <= req_cs;
        mem_addr <= req_addr;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: address only moves on an accepted request
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_take |=> $stable(mem_addr));

  // R3: never more than one chip select low
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R6: capture happens while the read strobe is low
  a_r6_cap_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> !mem_rd_n);

  // R8: a read that ends without a follow-on leaves every strobe high
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_take) |=> (mem_rd_n && &mem_cs_n));

  // R8: a chip select falls only after a clock with all selects high
  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~mem_cs_n & $past(mem_cs_n))) |-> &$past(mem_cs_n));

  // R5: done is followed either by a fresh cycle or by an idle state
  a_r5_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_take) |=> !done);

endmodule

// File: tb/smc_read_timer_bench.sv
module smc_read_timer_bench;
  localparam int NCS = 4, AW = 16, DW = 16, SETW = 6, PULW = 7, CYCW = 9, CSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [NCS*SETW-1:0] cfg_rs = '0, cfg_ss = '0;
  logic [NCS*PULW-1:0] cfg_rp = '0, cfg_sp = '0;
  logic [NCS*CYCW-1:0] cfg_cy = '0;
  logic [DW-1:0] mem_dq;
  logic req_take, mem_rd_n, cap_strobe, done;
  logic [AW-1:0] mem_addr;
  logic [NCS-1:0] mem_cs_n;
  logic [DW-1:0] rd_data;

  int tick = 0;
  int nchk = 0, nfail = 0;
  int mb = 0, mk = 0, mcs = 0, maddr = 0, mdata = 0;
  bit burst_watch = 0;
  logic [NCS-1:0] prev_cs = '1;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;
  assign mem_dq = mem_addr ^ tick[15:0];

  smc_read_timer u_smc_read_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs), .req_addr(req_addr),
    .cfg_rd_setup(cfg_rs), .cfg_rd_pulse(cfg_rp), .cfg_cs_setup(cfg_ss), .cfg_cs_pulse(cfg_sp),
    .cfg_cycle(cfg_cy), .mem_dq(mem_dq), .req_take(req_take), .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n), .cap_strobe(cap_strobe), .rd_data(rd_data),
    .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d at tick %0d", tag, act, exp, tick);
    end
  endtask

  function automatic int eff_cyc(input int cs);
    int c = int'(cfg_cy[cs*CYCW +: CYCW]);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int w_beg(input int s, input int c);
    return (s >= c) ? c - 1 : s;
  endfunction

  function automatic int w_end(input int s, input int p, input int c);
    int e = w_beg(s, c) + ((p == 0) ? 1 : p);
    return (e > c) ? c : e;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mb = 0; mk = 0; mcs = 0; maddr = 0; mdata = 0;
      prev_cs = '1;
    end else begin
      int c, rs, re, cb, ce, e_rd, e_cs, e_done, e_cap, e_take;
      bit odd;
      c  = eff_cyc(mcs);
      rs = int'(cfg_rs[mcs*SETW +: SETW]);
      re = w_end(rs, int'(cfg_rp[mcs*PULW +: PULW]), c);
      rs = w_beg(rs, c);
      cb = int'(cfg_ss[mcs*SETW +: SETW]);
      ce = w_end(cb, int'(cfg_sp[mcs*PULW +: PULW]), c);
      cb = w_beg(cb, c);
      odd = (int'(cfg_cy[mcs*CYCW +: CYCW]) == 0) || (int'(cfg_rs[mcs*SETW +: SETW]) >= c)
            || (cfg_rp[mcs*PULW +: PULW] == 0);
      e_rd   = (mb != 0 && mk >= rs && mk < re) ? 0 : 1;
      e_cs   = (mb != 0 && mk >= cb && mk < ce) ? 0 : 1;
      e_done = (mb != 0 && mk == c - 1) ? 1 : 0;
      e_cap  = (mb != 0 && mk == re - 1) ? 1 : 0;
      e_take = (req_valid && (mb == 0 || (e_done != 0 && int'(req_cs) == mcs))) ? 1 : 0;
      chk(odd ? "R4 rd strobe" : "R2 rd strobe", int'(mem_rd_n), e_rd);
      for (int i = 0; i < NCS; i++)
        chk("R3 chip select", int'(mem_cs_n[i]), (i == mcs) ? e_cs : 1);
      chk("R5 done", int'(done), e_done);
      chk("R6 capture", int'(cap_strobe), e_cap);
      chk("R6 read data", int'(rd_data), mdata);
      chk("R7 take", int'(req_take), e_take);
      chk("R1 address", int'(mem_addr), maddr);
      if ((~mem_cs_n & prev_cs) != '0) chk("R8 idle before select", int'(&prev_cs), 1);
      if (burst_watch) chk("R9 continuous strobe", int'({mem_rd_n, mem_cs_n[1]}), 0);
      prev_cs = mem_cs_n;
      if (e_cap != 0) mdata = int'(mem_dq);
      if (e_take != 0) begin
        mb = 1; mk = 0; mcs = int'(req_cs); maddr = int'(req_addr);
      end else if (e_done != 0) mb = 0;
      else if (mb != 0) mk++;
    end
  end

  task automatic set_cfg(input int cs, input int rs, input int rp, input int ss, input int sp,
                         input int cy);
    cfg_rs[cs*SETW +: SETW] = SETW'(rs);
    cfg_rp[cs*PULW +: PULW] = PULW'(rp);
    cfg_ss[cs*SETW +: SETW] = SETW'(ss);
    cfg_sp[cs*PULW +: PULW] = PULW'(sp);
    cfg_cy[cs*CYCW +: CYCW] = CYCW'(cy);
  endtask

  task automatic issue(input int cs, input int a);
    req_valid = 1'b1; req_cs = CSW'(cs); req_addr = AW'(a);
    do @(negedge clk); while (!req_take);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (mb != 0);
    @(posedge clk); #2;
  endtask

  initial begin
    set_cfg(0, 2, 3, 1, 5, 8);
    set_cfg(1, 0, 4, 0, 4, 4);
    set_cfg(2, 5, 20, 3, 0, 10);
    set_cfg(3, 10, 0, 7, 2, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rd", int'(mem_rd_n), 1);
    chk("R10 reset cs", int'(mem_cs_n), 15);
    chk("R10 reset flags", int'({done, cap_strobe, req_take}), 0);
    chk("R10 reset data", int'(rd_data), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    issue(0, 16'h1234);
    drain();
    issue(1, 16'h0100);
    burst_watch = 1;
    issue(1, 16'h0101);
    issue(1, 16'h0102);
    @(negedge clk iff done);
    burst_watch = 0;
    drain();
    issue(2, 16'h2000);
    issue(3, 16'h3000);
    issue(3, 16'h3001);
    issue(1, 16'h1111);
    issue(2, 16'h2222);
    issue(0, 16'h0ABC);
    drain();
    for (int r = 0; r < 3; r++) begin
      for (int cs = 0; cs < NCS; cs++)
        set_cfg(cs, $urandom_range(0, 12), $urandom_range(0, 14), $urandom_range(0, 12),
                $urandom_range(0, 14), $urandom_range(0, 30));
      for (int n = 0; n < 60; n++) begin
        issue($urandom_range(0, 3), $urandom_range(0, 65535));
        if ($urandom_range(0, 4) == 0) repeat ($urandom_range(1, 6)) @(posedge clk);
        #1;
      end
      drain();
    end
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    wait (tick > 150000);
    nfail++;
    $display("FAIL watchdog actual %0d expected below 150000", tick);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule